// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block joins two 18-bit buses, called side A and side B. Each direction has its own storage element. The A-to-B path and the B-to-A path each have three controls: a latch enable, a path clock and an output enable. While its latch enable is high, a path is transparent: the far side shows the near-side input in the same cycle. While the latch enable is low, the path holds its stored word. It loads a new word only when its path clock goes from low to high.

The block is synchronous to a system clock `clk`, and the path clocks are treated as data. A path clock is sampled at every rising edge of `clk`. A sample of 1 that follows a sample of 0 counts as one load event. The word loaded is the near-side input present at that edge. While a path is transparent, its storage also takes the input at every system edge. When the latch enable falls, the word that was passing through is therefore kept.

Each side is modelled as a data vector plus one drive-enable bit, and a deasserted enable stands for high impedance. A wrapper at the chip edge can map this pair onto a tri-state pad. The A-to-B output enable is active high. The B-to-A output enable is active low. An active-low asynchronous reset clears both stored words and both sampled path-clock levels to zero.

Top module: `dual_path_bus_register`

## Requirements
- R1: After reset, both stored words read 0 on a side whose path has its latch enable low.
- R2: While `le_ab` is high, `b_out` equals `a_in` in the same cycle, and while `le_ba` is high, `a_out` equals `b_in`.
- R3: While a path's latch enable is low and its clock is held at a constant level, either low or high, the output of that path keeps its word and ignores changes at the input.
- R4: While a path's latch enable is low, a system-clock edge at which the path clock samples 1 after a previous sample of 0 loads the input present at that edge. The output shows the new word from that edge on.
- R5: If the latch enable falls while the path clock is high, the output keeps the word that was passing through, which is the input at the last system edge before the fall. It keeps that word until the next load event or until transparency resumes.
- R6: The latch enable has priority over the path clock. While it is high, the output follows the input with or without a path-clock edge.
- R7: `b_oe` is 1 exactly when `oe_ab` is 1, and `a_oe` is 1 exactly when `oe_ba_n` is 0. Toggling either enable does not change the stored word, which shows again when the enable is reasserted.
- R8: The two directions are independent. Activity on the controls or inputs of one path does not change the output of the other path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples path clocks and updates storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | WIDTH | Word received on side A |
| a_out | output | WIDTH | Word driven onto side A (B-to-A path) |
| a_oe | output | 1 | Side A drive enable; 0 means high impedance |
| b_in | input | WIDTH | Word received on side B |
| b_out | output | WIDTH | Word driven onto side B (A-to-B path) |
| b_oe | output | 1 | Side B drive enable; 0 means high impedance |
| le_ab | input | 1 | A-to-B latch enable, 1 = transparent |
| clk_ab | input | 1 | A-to-B path clock, loads on low-to-high |
| oe_ab | input | 1 | A-to-B output enable, active high |
| le_ba | input | 1 | B-to-A latch enable, 1 = transparent |
| clk_ba | input | 1 | B-to-A path clock, loads on low-to-high |
| oe_ba_n | input | 1 | B-to-A output enable, active low |

## Verification
The bench builds the block with the default `WIDTH` of 18. At that width, random words drive every bit lane with both levels. A stuck or swapped lane in either direction therefore shows up as a mismatch against the bench's own model. The random mix keeps the latch enables mostly low and toggles the path clocks at random. This reaches holds with the path clock low and with it high, back-to-back load events, and latch-enable falls with the path clock high or low, in both directions at once.

// File: rtl/dual_path_bus_register.sv
module dual_path_bus_register #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             le_ab,
  input  logic             clk_ab,
  input  logic             oe_ab,
  input  logic             le_ba,
  input  logic             clk_ba,
  input  logic             oe_ba_n
);

  logic [WIDTH-1:0] ab_word, ba_word;
  logic             ab_lvl, ba_lvl;
  logic             ab_load, ba_load;

  assign ab_load = le_ab | (clk_ab & ~ab_lvl);
  assign ba_load = le_ba | (clk_ba & ~ba_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_word <= '0;
      ab_lvl  <= 1'b0;
    end else begin
      ab_lvl <= clk_ab;
      if (ab_load) ab_word <= a_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ba_word <= '0;
      ba_lvl  <= 1'b0;
    end else begin
      ba_lvl <= clk_ba;
      if (ba_load) ba_word <= b_in;
    end
  end

  assign b_out = le_ab ? a_in : ab_word;
  assign a_out = le_ba ? b_in : ba_word;
  assign b_oe  = oe_ab;
  assign a_oe  = ~oe_ba_n;

endmodule

// File: rtl/dual_path_bus_register_chk.sv
module dual_path_bus_register_chk #(
  parameter int WIDTH = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_oe,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic             b_oe,
  input logic             le_ab,
  input logic             clk_ab,
  input logic             oe_ab,
  input logic             le_ba,
  input logic             clk_ba,
  input logic             oe_ba_n
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !le_ab && !le_ba) |-> (b_out == '0 && a_out == '0));

  p_transparent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    le_ab |-> b_out == a_in);

  p_transparent_ba_r2: assert property (@(posedge clk) disable iff (!rst_n)
    le_ba |-> a_out == b_in);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !le_ab && !(clk_ab && !$past(clk_ab))) |=> (le_ab || $stable(b_out)));

  p_hold_ba_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !le_ba && !(clk_ba && !$past(clk_ba))) |=> (le_ba || $stable(a_out)));

  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !le_ab && clk_ab && !$past(clk_ab)) |=> (le_ab || b_out == $past(a_in)));

  p_capture_ba_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !le_ba && clk_ba && !$past(clk_ba)) |=> (le_ba || a_out == $past(b_in)));

  p_fall_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (le_ab) |=> (le_ab || clk_ab || b_out == $past(a_in)));

endmodule

bind dual_path_bus_register dual_path_bus_register_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/dual_path_bus_register_tb_top.sv
`timescale 1ns/1ps
module dual_path_bus_register_tb_top;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0, a_out, b_out;
  logic a_oe, b_oe;
  logic le_ab = 0, clk_ab = 0, oe_ab = 0, le_ba = 0, clk_ba = 0, oe_ba_n = 1;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dual_path_bus_register #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .le_ab(le_ab), .clk_ab(clk_ab),
    .oe_ab(oe_ab), .le_ba(le_ba), .clk_ba(clk_ba), .oe_ba_n(oe_ba_n));

  logic [W-1:0] m_ab, m_ba;
  logic m_pab, m_pba;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ab <= '0; m_ba <= '0; m_pab <= 0; m_pba <= 0;
    end else begin
      if (le_ab || (clk_ab && !m_pab)) m_ab <= a_in;
      if (le_ba || (clk_ba && !m_pba)) m_ba <= b_in;
      m_pab <= clk_ab;
      m_pba <= clk_ba;
    end
  end

  function automatic logic [W-1:0] seen(input logic le, input logic [W-1:0] din,
                                        input logic [W-1:0] st);
    return le ? din : st;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  task automatic model_check(input string ph);
    string tb, ta;
    tb = le_ab ? "R2" : ((clk_ab && !m_pab) ? "R4" : "R3");
    ta = le_ba ? "R2" : ((clk_ba && !m_pba) ? "R4" : "R3");
    chk({tb, " b_out ", ph}, b_out, seen(le_ab, a_in, m_ab));
    chk({ta, " a_out ", ph}, a_out, seen(le_ba, b_in, m_ba));
    chk("R7 b_oe", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, oe_ab});
    chk("R7 a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, ~oe_ba_n});
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    step(3);
    rst_n = 1;
    #1;
    chk("R1 b_out after reset", b_out, '0);
    chk("R1 a_out after reset", a_out, '0);
    chk("R7 b_oe low when oe_ab=0", {17'b0, b_oe}, '0);
    chk("R7 a_oe low when oe_ba_n=1", {17'b0, a_oe}, '0);
    step();

    le_ab = 1; a_in = 18'h2A5A5; #1;
    chk("R2 transparent", b_out, 18'h2A5A5);
    a_in = 18'h15A5A; #1;
    chk("R2 transparent follow", b_out, 18'h15A5A);
    step();

    le_ab = 0; a_in = 18'h3FFFF; #1;
    chk("R3 hold clk low", b_out, 18'h15A5A);
    step(2);
    chk("R3 hold clk low later", b_out, 18'h15A5A);

    clk_ab = 1; a_in = 18'h01234; step();
    chk("R4 rising path clock loads", b_out, 18'h01234);
    a_in = 18'h0BEEF; step(3);
    chk("R3 hold clk high", b_out, 18'h01234);

    le_ab = 1; a_in = 18'h2C3C3; step();
    le_ab = 0; step();
    a_in = 18'h00001; step();
    chk("R5 le fall with clock high keeps passing word", b_out, 18'h2C3C3);

    clk_ab = 0; le_ab = 1; a_in = 18'h11111; step();
    clk_ab = 1; a_in = 18'h22222; step();
    chk("R6 le over edge", b_out, 18'h22222);
    a_in = 18'h33333; #1;
    chk("R6 still transparent after edge", b_out, 18'h33333);
    step(); le_ab = 0; clk_ab = 0; a_in = 18'h0; step();
    chk("R5 held after le fall", b_out, 18'h33333);

    oe_ab = 1; #1;
    chk("R7 b_oe high", {17'b0, b_oe}, 18'h1);
    step(); oe_ab = 0; step(); oe_ab = 1; #1;
    chk("R7 word kept across disable", b_out, 18'h33333);

    oe_ba_n = 0; le_ba = 1; b_in = 18'h0F0F0; #1;
    chk("R7 a_oe high", {17'b0, a_oe}, 18'h1);
    chk("R2 ba transparent", a_out, 18'h0F0F0);
    step(); le_ba = 0; b_in = 18'h30303; clk_ba = 1; step();
    chk("R4 ba load", a_out, 18'h30303);
    chk("R8 ab untouched by ba", b_out, 18'h33333);
    a_in = 18'h3AAAA; clk_ab = 1; b_in = 18'h00055; step();
    chk("R8 ba untouched by ab load", a_out, 18'h30303);
    chk("R4 ab load", b_out, 18'h3AAAA);

    for (int i = 0; i < 3000; i++) begin
      model_check("pre");
      a_in    = W'($urandom);
      b_in    = W'($urandom);
      le_ab   = ($urandom_range(0, 3) == 0);
      le_ba   = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 1)) clk_ab = ~clk_ab;
      if ($urandom_range(0, 1)) clk_ba = ~clk_ba;
      oe_ab   = $urandom_range(0, 1);
      oe_ba_n = $urandom_range(0, 1);
      #1;
      model_check("post");
      step();
    end
    summary();
  end
endmodule